// File: doc/BRIEF.md
# Victim Line Buffer

A small, fully associative side store placed next to a direct-mapped data cache. Every line that the direct-mapped array throws out on replacement is handed to this buffer instead of being lost. The cache controller keeps its normal single-lookup hit path. Only when the main array misses does it ask the buffer whether the wanted line is still held here.

If the buffer holds the line, the line goes back to the controller to be written into the main array. In the same transaction, the line that the main array displaces takes the vacated slot. The requester therefore sees such a hit one cycle after a main-array hit. If the buffer misses, the request goes on to the lower level. A new victim then overwrites the oldest slot. When the overwritten entry is dirty, it is passed down on a writeback port; when it is clean, it is dropped.

Entries are not tied to a set, so each entry is identified by the full block address: tag and index together. Line data sits in a simple dual-port RAM that has one read port and one write port. The address and status bits sit in flip-flops so that all entries can be compared at once.

Top module: `victim_buf`

## Requirements
- R1: After synchronous reset every entry is invalid, `rsp_valid` and `wb_valid` are low, and the first lookup misses.
- R2: A lookup presented in cycle t gives `rsp_valid`=1 in cycle t+1. `rsp_hit` is 1 exactly when a valid entry holds a block address equal to {`lk_tag`,`lk_idx`}.
- R3: On a hit, `sw_tag`, `sw_idx`, `sw_data` and `sw_dirty` in cycle t+1 carry the stored line, address and dirty bit of the matching entry.
- R4: A lookup hit together with an eviction in the same cycle stores the evicted line in the slot that hit. A later lookup of the evicted line hits and returns its data. A later lookup of the swapped-out line misses.
- R5: A lookup hit with no eviction in the same cycle frees the entry, so a repeat lookup of that line misses.
- R6: An eviction without a lookup hit is written to the slot named by a rotating pointer. The pointer starts at slot 0 and advances by one, wrapping, per such insertion, so the fifth insertion replaces the first.
- R7: When an insertion under R6 overwrites a valid dirty entry, `wb_valid` is 1 in the next cycle with that entry's tag, index and data on `wb_tag`, `wb_idx` and `wb_data`.
- R8: When the overwritten entry is clean or invalid, no writeback is raised (`wb_valid`=0).
- R9: A lookup compares only against entries stored before its cycle. A miss with an eviction of the same address in that cycle reports a miss and still inserts the line as in R6.
- R10: A match needs both tag and index equal. An entry with the same tag and another index, or the same index and another tag, does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup after a main-array miss |
| lk_tag | input | TAG_W | Lookup tag |
| lk_idx | input | IDX_W | Lookup index |
| ev_valid | input | 1 | Line evicted from main array this cycle |
| ev_tag | input | TAG_W | Evicted line tag |
| ev_idx | input | IDX_W | Evicted line index |
| ev_data | input | LINE_W | Evicted line data |
| ev_dirty | input | 1 | Evicted line is modified |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup found the line here |
| sw_tag | output | TAG_W | Tag of line returned to main array |
| sw_idx | output | IDX_W | Index of line returned to main array |
| sw_data | output | LINE_W | Data of line returned to main array |
| sw_dirty | output | 1 | Dirty bit of returned line |
| wb_valid | output | 1 | Dirty line leaving toward lower level |
| wb_tag | output | TAG_W | Writeback tag |
| wb_idx | output | IDX_W | Writeback index |
| wb_data | output | LINE_W | Writeback data |

## Verification
A lookup and an incoming eviction can arrive in the same cycle. The buffer then either swaps the line in place (lookup hit) or inserts the eviction and may push a dirty entry out (lookup miss). The bench drives both inputs together in directed cases, and also in a random stream over a 16-address space that keeps the four slots under constant pressure. It judges every cycle against a bench-side model of slots, pointer and dirty bits, and compares the swap and writeback ports field by field.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // width of a slot pointer for n entries (at least one bit)
  function automatic int slot_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ENTRIES = 4,
  parameter int AW      = 12,
  localparam int SW     = vb_pkg::slot_bits(ENTRIES)
) (
  input  logic [ENTRIES-1:0][AW-1:0] addr_q,
  input  logic [ENTRIES-1:0]         valid_q,
  input  logic [AW-1:0]              key,
  output logic [ENTRIES-1:0]         match,
  output logic                       any,
  output logic [SW-1:0]              slot
);
  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (addr_q[g] == key);
  end

  assign any = |match;

  always_comb begin
    slot = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) slot = SW'(i);
  end
endmodule

// File: rtl/vb_line_ram.sv
module vb_line_ram #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 64,
  localparam int AW   = vb_pkg::slot_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-first: a same-slot write returns the old line
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 8,
  parameter int IDX_W   = 4,
  parameter int LINE_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic              ev_valid,
  input  logic [TAG_W-1:0]  ev_tag,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic [LINE_W-1:0] ev_data,
  input  logic              ev_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [TAG_W-1:0]  sw_tag,
  output logic [IDX_W-1:0]  sw_idx,
  output logic [LINE_W-1:0] sw_data,
  output logic              sw_dirty,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [LINE_W-1:0] wb_data
);
  localparam int AW = TAG_W + IDX_W;
  localparam int SW = vb_pkg::slot_bits(ENTRIES);

  logic [ENTRIES-1:0][AW-1:0] addr_q;
  logic [ENTRIES-1:0]         valid_q, dirty_q;
  logic [SW-1:0]              ptr_q;

  logic [ENTRIES-1:0] match;
  logic               any;
  logic [SW-1:0]      hit_slot;
  logic               lk_hit, advance, displace;
  logic [SW-1:0]      wslot, rslot;
  logic [AW-1:0]      key, ev_addr;
  logic [LINE_W-1:0]  ram_q;

  assign key     = {lk_tag, lk_idx};
  assign ev_addr = {ev_tag, ev_idx};

  vb_match #(.ENTRIES(ENTRIES), .AW(AW)) u_match (
    .addr_q (addr_q),
    .valid_q(valid_q),
    .key    (key),
    .match  (match),
    .any    (any),
    .slot   (hit_slot)
  );

  assign lk_hit   = lk_valid && any;
  assign advance  = ev_valid && !lk_hit;
  assign displace = advance && valid_q[ptr_q] && dirty_q[ptr_q];
  assign wslot    = lk_hit ? hit_slot : ptr_q;
  // one read port serves both the swap-out and the writeback
  assign rslot    = lk_hit ? hit_slot : ptr_q;

  vb_line_ram #(.DEPTH(ENTRIES), .WIDTH(LINE_W)) u_ram (
    .clk  (clk),
    .we   (ev_valid),
    .waddr(wslot),
    .wdata(ev_data),
    .raddr(rslot),
    .q    (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (ev_valid) begin
        valid_q[wslot] <= 1'b1;
        dirty_q[wslot] <= ev_dirty;
        addr_q[wslot]  <= ev_addr;
      end else if (lk_hit) begin
        valid_q[hit_slot] <= 1'b0;
      end
      if (advance)
        ptr_q <= (ptr_q == SW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      wb_valid  <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      wb_valid  <= displace;
    end
    {sw_tag, sw_idx} <= addr_q[hit_slot];
    sw_dirty         <= dirty_q[hit_slot];
    {wb_tag, wb_idx} <= addr_q[ptr_q];
  end

  assign sw_data = ram_q;
  assign wb_data = ram_q;

  // R2: each lookup is answered exactly one cycle later
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  // R2: no duplicate lines, at most one comparator fires
  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  // R1: an empty buffer never hits
  a_r1_empty_miss: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && valid_q == '0) |=> !rsp_hit);
  // R3: returned address equals the requested one
  a_r3_sw_addr: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!rsp_hit || {sw_tag, sw_idx} == $past(key)));
  // R7: a writeback and a swap-out never share a cycle
  a_r7_wb_excl: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !rsp_hit);
  // R8: writebacks only follow an incoming eviction
  a_r8_wb_cause: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(ev_valid));
endmodule

// File: tb/sim_victim_buf.sv
`timescale 1ns/1ps
module sim_victim_buf;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int IW = 4;
  localparam int LW = 64;

  logic clk = 1'b0;
  logic rst;
  logic lk_valid, ev_valid, ev_dirty;
  logic [TW-1:0] lk_tag, ev_tag;
  logic [IW-1:0] lk_idx, ev_idx;
  logic [LW-1:0] ev_data;
  logic rsp_valid, rsp_hit, sw_dirty, wb_valid;
  logic [TW-1:0] sw_tag, wb_tag;
  logic [IW-1:0] sw_idx, wb_idx;
  logic [LW-1:0] sw_data, wb_data;

  always #10 clk = ~clk;

  victim_buf #(.ENTRIES(N), .TAG_W(TW), .IDX_W(IW), .LINE_W(LW)) u0 (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_idx(lk_idx),
    .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_idx(ev_idx),
    .ev_data(ev_data), .ev_dirty(ev_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .sw_tag(sw_tag), .sw_idx(sw_idx), .sw_data(sw_data), .sw_dirty(sw_dirty),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model
  bit                 m_v [N];
  bit                 m_d [N];
  logic [TW+IW-1:0]   m_a [N];
  logic [LW-1:0]      m_q [N];
  int                 m_p;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [TW+IW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction

  task automatic step(input bit lv, input logic [TW-1:0] lt, input logic [IW-1:0] li,
                      input bit ev, input logic [TW-1:0] et, input logic [IW-1:0] ei,
                      input logic [LW-1:0] ed, input bit edy, input string req);
    int h;
    bit xh, xwb;
    logic [TW+IW-1:0] xsa, xwa;
    logic [LW-1:0] xsd, xwd;
    bit xsdy;
    lk_valid = lv; lk_tag = lt; lk_idx = li;
    ev_valid = ev; ev_tag = et; ev_idx = ei; ev_data = ed; ev_dirty = edy;
    h = lv ? find({lt, li}) : -1;
    xh = (h >= 0);
    xwb = 0; xsa = '0; xsd = '0; xsdy = 0; xwa = '0; xwd = '0;
    if (xh) begin xsa = m_a[h]; xsd = m_q[h]; xsdy = m_d[h]; end
    if (ev) begin
      if (xh) begin
        m_a[h] = {et, ei}; m_q[h] = ed; m_d[h] = edy; m_v[h] = 1;
      end else begin
        xwb = m_v[m_p] && m_d[m_p]; xwa = m_a[m_p]; xwd = m_q[m_p];
        m_a[m_p] = {et, ei}; m_q[m_p] = ed; m_d[m_p] = edy; m_v[m_p] = 1;
        m_p = (m_p + 1) % N;
      end
    end else if (xh) m_v[h] = 0;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == lv, {req, " R2 rsp_valid"}, 64'(rsp_valid), 64'(lv));
    if (lv) chk(rsp_hit == xh, {req, " R2 R10 rsp_hit"}, 64'(rsp_hit), 64'(xh));
    if (xh) begin
      chk({sw_tag, sw_idx} == xsa, {req, " R3 sw addr"}, 64'({sw_tag, sw_idx}), 64'(xsa));
      chk(sw_data == xsd, {req, " R3 sw data"}, sw_data, xsd);
      chk(sw_dirty == xsdy, {req, " R3 sw dirty"}, 64'(sw_dirty), 64'(xsdy));
    end
    chk(wb_valid == xwb, {req, " R7 R8 wb_valid"}, 64'(wb_valid), 64'(xwb));
    if (xwb) begin
      chk({wb_tag, wb_idx} == xwa, {req, " R7 wb addr"}, 64'({wb_tag, wb_idx}), 64'(xwa));
      chk(wb_data == xwd, {req, " R7 wb data"}, wb_data, xwd);
    end
  endtask

  task automatic idle();
    lk_valid = 0; ev_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = 0; m_a[i] = '0; m_q[i] = '0; end
    m_p = 0;
    rst = 1; idle(); lk_tag = '0; lk_idx = '0; ev_tag = '0; ev_idx = '0;
    ev_data = '0; ev_dirty = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(rsp_valid == 0, "R1 rsp_valid after reset", 64'(rsp_valid), 0);
    chk(wb_valid == 0, "R1 wb_valid after reset", 64'(wb_valid), 0);
    step(1, 8'h01, 4'h1, 0, 0, 0, 0, 0, "R1");
    // R6: fill four slots, even ones dirty
    for (int i = 0; i < 4; i++)
      step(0, 0, 0, 1, 8'h10 + 8'(i), 4'(i), {32'hA5A5_0000, 32'(i)}, (i % 2) == 0, "R6");
    // R4: swap with a line of the same index
    step(1, 8'h11, 4'h1, 1, 8'h20, 4'h1, 64'hDEAD_BEEF_0000_0020, 1, "R4");
    step(1, 8'h11, 4'h1, 0, 0, 0, 0, 0, "R4");
    step(1, 8'h20, 4'h1, 0, 0, 0, 0, 0, "R4");
    // R5: the hit above freed the slot
    step(1, 8'h20, 4'h1, 0, 0, 0, 0, 0, "R5");
    // R10: partial matches
    step(1, 8'h12, 4'h3, 0, 0, 0, 0, 0, "R10");
    step(1, 8'h13, 4'h2, 0, 0, 0, 0, 0, "R10");
    // R9: miss while the same line is inserted, then it hits
    step(1, 8'h30, 4'h5, 1, 8'h30, 4'h5, 64'h1234_5678_9ABC_DEF0, 0, "R9");
    step(1, 8'h30, 4'h5, 0, 0, 0, 0, 0, "R9");
    // R7 R8: overflow with dirty and clean victims
    for (int i = 0; i < 6; i++)
      step(0, 0, 0, 1, 8'h50 + 8'(i), 4'(i), {32'h0BAD_0000, 32'(i)}, 1, "R7");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit lv, ev;
      logic [TW-1:0] lt, et;
      logic [IW-1:0] li, ei;
      lv = 1'($urandom % 2); ev = 1'($urandom % 2);
      lt = 8'($urandom % 4); li = 4'($urandom % 4);
      et = 8'($urandom % 4); ei = 4'($urandom % 4);
      if (find({et, ei}) >= 0) ev = 0;
      step(lv, lt, li, ev, et, ei, {$urandom, $urandom}, 1'($urandom % 2), "RND");
    end
    idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule